// File: doc/BRIEF.md
# Clock Output Channel with Source Select and Coded Post Divider

This block produces one output clock of a multi-output clock generator. Four candidate clocks arrive as levels on `src_i`: a reference and three synthesized clocks. A 2-bit select picks one of them, and a post divider divides the chosen clock by a ratio taken from a fixed 16-entry table, indexed by a 4-bit code. The block runs on a fast system clock. It samples the candidate clocks and counts rising edges of the selected one, so its output changes in step with that clock after a fixed pipeline delay.

A channel built with two banks holds two copies of the select and ratio code, and a bank pin chooses between them at run time. A power-down enable, together with a global power-down pin, parks the output low. An output-enable pin releases the output to high impedance, and that release overrides everything else. After reset all settings are zero, so the channel passes the reference through undivided. Switching the source or the ratio while running may glitch the output.

Top module: `clkout_channel`

## Requirements
- R1: The source select picks the candidate clock from `src_i`: code 00 picks bit 0 (reference), 01 picks bit 1 (synth A), 10 picks bit 2 (synth B), 11 picks bit 3 (synth C).
- R2: Ratio codes 0 to 15 divide the chosen clock by 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25, 50 in that order. The output period is that many periods of the chosen clock.
- R3: For a divide value N of 2 or more, the output stays high for floor(N/2) periods of the chosen clock in every output period. For divide-by-1 the output follows the chosen clock level.
- R4: While the power-down enable and the power-down pin are both 1, the output is driven low, starting no later than the second system clock edge.
- R5: While output enable is 0, `clk_o` is high impedance, whatever the power-down and divider state.
- R6: With the two-bank variant, bank pin 0 applies select 1 and code 1, and bank pin 1 applies select 2 and code 2.
- R7: During reset the output is low. After reset, with all settings zero, the output reproduces the reference clock (same period and high time).
- R8: A change of the applied ratio code restarts the divider count from zero. The output is high by the third system clock edge after the change, for any new divide value of 2 or more.
- R9: The power-down enable alone, or the power-down pin alone, leaves the divided output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than every candidate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Candidate clock levels, bit 0 reference, bits 1..3 synthesized clocks |
| bank_sel_i | input | 1 | Bank pin: 0 applies bank 1, 1 applies bank 2 |
| src_sel1_i | input | SEL_W | Source select, bank 1 |
| ratio_code1_i | input | 4 | Ratio code, bank 1 |
| src_sel2_i | input | SEL_W | Source select, bank 2 |
| ratio_code2_i | input | 4 | Ratio code, bank 2 |
| pd_en_i | input | 1 | Power-down enable for this channel |
| pd_pin_i | input | 1 | Global power-down pin |
| oe_i | input | 1 | Output enable, 0 releases the output |
| clk_o | output | 1 | Divided output clock, tristated when disabled |

## Verification
A wrong count in the divider shows up at the pin as a wrong period or a wrong high time within one output period, which can take up to fifty periods of the chosen clock. A count that misses its restart shows up much sooner: the output fails to rise within three system cycles of a code change. A stale bank or select decision changes the measured period at once, because each candidate clock in the bench has its own distinct period. A power-down path that does not take effect leaves the pin toggling two cycles after the pins assert.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int CODE_W  = 4;
  localparam int DIV_TOP = 50;

  typedef enum logic [1:0] {
    SRC_REF   = 2'd0,
    SRC_SYN_A = 2'd1,
    SRC_SYN_B = 2'd2,
    SRC_SYN_C = 2'd3
  } src_e;

  // divide value for each ratio code (non-uniform table)
  function automatic int unsigned div_of(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    div_of = 1;
      4'd1:    div_of = 2;
      4'd2:    div_of = 3;
      4'd3:    div_of = 4;
      4'd4:    div_of = 5;
      4'd5:    div_of = 6;
      4'd6:    div_of = 8;
      4'd7:    div_of = 9;
      4'd8:    div_of = 10;
      4'd9:    div_of = 12;
      4'd10:   div_of = 15;
      4'd11:   div_of = 16;
      4'd12:   div_of = 18;
      4'd13:   div_of = 20;
      4'd14:   div_of = 25;
      default: div_of = DIV_TOP;
    endcase
  endfunction

endpackage

// File: rtl/clkout_bank_sel.sv
module clkout_bank_sel
  import clkout_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit DUAL_BANK = 1'b1
) (
  input  logic              bank_i,
  input  logic [SEL_W-1:0]  sel1_i,
  input  logic [CODE_W-1:0] code1_i,
  input  logic [SEL_W-1:0]  sel2_i,
  input  logic [CODE_W-1:0] code2_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CODE_W-1:0] code_o
);

  generate
    if (DUAL_BANK) begin : g_dual
      // R6: bank pin chooses the applied settings
      always_comb begin
        sel_o  = bank_i ? sel2_i  : sel1_i;
        code_o = bank_i ? code2_i : code1_i;
      end
    end else begin : g_single
      logic unused_bank2;
      assign unused_bank2 = ^{bank_i, sel2_i, code2_i};
      always_comb begin
        sel_o  = sel1_i;
        code_o = code1_i;
      end
    end
  endgenerate

endmodule

// File: rtl/clkout_src_pick.sv
module clkout_src_pick #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               lvl_o,
  output logic               rise_o
);

  logic [NUM_SRC-1:0] smp_q;
  logic               prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      smp_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= src_i;
      prev_q <= lvl_o;
    end
  end

  // R1: select indexes the sampled candidate clocks
  assign lvl_o  = smp_q[sel_i];
  assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/clkout_post_div.sv
module clkout_post_div
  import clkout_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              lvl_i,
  input  logic              rise_i,
  input  logic              halt_i,
  output logic              out_o
);

  logic [CNT_W-1:0]  ratio;
  logic [CNT_W-1:0]  half;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              out_q;

  assign ratio = CNT_W'(div_of(code_i));
  assign half  = ratio >> 1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      code_q <= '0;
      out_q  <= 1'b0;
    end else begin
      code_q <= code_i;
      if (halt_i) begin
        cnt_q <= '0;
        out_q <= 1'b0;
      end else begin
        if (code_i != code_q) begin
          cnt_q <= '0;                         // R8: restart on new ratio
        end else if (rise_i) begin
          cnt_q <= (cnt_q >= ratio - 1'b1) ? '0 : cnt_q + 1'b1;
        end
        // R3: high for floor(N/2) periods, divide-by-1 follows the level
        out_q <= (ratio == CNT_W'(1)) ? lvl_i : (cnt_q < half);
      end
    end
  end

  assign out_o = out_q;

  // R2: count never leaves the range of the applied ratio
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < CNT_W'(div_of(code_q)));

  // R8: a code change brings the count back to zero
  p_restart_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!halt_i && code_i != code_q) |=> (cnt_q == '0));

  // R3: divide-by-1 output is the level seen one edge earlier
  p_div1_follow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!halt_i && ratio == CNT_W'(1)) |=> (out_q == $past(lvl_i)));

  // R2: without a rising source edge the count holds
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!halt_i && !rise_i && code_i == code_q) |=> $stable(cnt_q));

endmodule

// File: rtl/clkout_channel.sv
module clkout_channel
  import clkout_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int SEL_W     = $clog2(NUM_SRC),
  parameter int CNT_W     = $clog2(DIV_TOP + 1),
  parameter bit DUAL_BANK = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bank_sel_i,
  input  logic [SEL_W-1:0]   src_sel1_i,
  input  logic [CODE_W-1:0]  ratio_code1_i,
  input  logic [SEL_W-1:0]   src_sel2_i,
  input  logic [CODE_W-1:0]  ratio_code2_i,
  input  logic               pd_en_i,
  input  logic               pd_pin_i,
  input  logic               oe_i,
  output logic               clk_o
);

  logic [SEL_W-1:0]  sel_app;
  logic [CODE_W-1:0] code_app;
  logic              lvl;
  logic              rise;
  logic              halt;
  logic              div_out;

  clkout_bank_sel #(.SEL_W(SEL_W), .DUAL_BANK(DUAL_BANK)) u_bank (
    .bank_i (bank_sel_i),
    .sel1_i (src_sel1_i),
    .code1_i(ratio_code1_i),
    .sel2_i (src_sel2_i),
    .code2_i(ratio_code2_i),
    .sel_o  (sel_app),
    .code_o (code_app)
  );

  clkout_src_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .src_i (src_i),
    .sel_i (sel_app),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  // R4/R9: only both together park the output
  assign halt = pd_en_i & pd_pin_i;

  clkout_post_div #(.CNT_W(CNT_W)) u_div (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .code_i(code_app),
    .lvl_i (lvl),
    .rise_i(rise),
    .halt_i(halt),
    .out_o (div_out)
  );

  // R5: release has priority over everything
  assign clk_o = oe_i ? div_out : 1'bz;

  // R4: power-down drives the divided output low
  p_pd_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    halt |=> !div_out);

endmodule

// File: tb/clkout_channel_bench.sv
module clkout_channel_bench;

  typedef struct {
    int    hi;
    int    per;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src = 4'b0;
  logic       bank = 1'b0;
  logic [1:0] sel1 = 2'd0, sel2 = 2'd0;
  logic [3:0] code1 = 4'd0, code2 = 4'd0;
  logic       pd_en = 1'b0, pd_pin = 1'b0, oe = 1'b1;
  wire        clk_o;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  // candidate clock periods in system cycles: ref, A, B, C
  int src_per [4] = '{8, 6, 10, 4};
  int div_tab [16] = '{1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25, 50};

  always #10 clk = ~clk;   // 50 MHz

  clkout_channel u_clkout_channel (
    .clk_i(clk), .rst_i(rst), .src_i(src), .bank_sel_i(bank),
    .src_sel1_i(sel1), .ratio_code1_i(code1),
    .src_sel2_i(sel2), .ratio_code2_i(code2),
    .pd_en_i(pd_en), .pd_pin_i(pd_pin), .oe_i(oe), .clk_o(clk_o)
  );

  // candidate clocks toggle on falling edges
  for (genvar g = 0; g < 4; g++) begin : g_src
    initial forever begin
      repeat (src_per[g] / 2) @(negedge clk);
      src[g] = ~src[g];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver side: push expectation, wait until the monitor has consumed it
  task automatic expect_shape(input int hi, input int per, input string tag);
    exp_t e;
    e.hi = hi; e.per = per; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  function automatic int exp_hi(input int n, input int p);
    return (n == 1) ? p / 2 : (n / 2) * p;
  endfunction

  task automatic settle(input int n, input int p);
    repeat (2 * n * p + 20) @(negedge clk);
  endtask

  // monitor: measure one full output period and compare
  initial forever begin
    int hi, lo;
    exp_t e;
    wait (exp_q.size() != 0);
    @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    hi = 0;
    while (clk_o === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (clk_o === 1'b0) begin lo++; @(negedge clk); end
    e = exp_q[0];
    check(hi == e.hi, {e.tag, " high time"}, hi, e.hi);
    check(hi + lo == e.per, {e.tag, " period"}, hi + lo, e.per);
    void'(exp_q.pop_front());
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: low during reset
    repeat (5) @(negedge clk);
    check(clk_o === 1'b0, "R7 output in reset", int'(clk_o), 0);
    rst = 1'b0;
    settle(1, 8);
    expect_shape(4, 8, "R7 reference passthrough");

    // R1: each select code with divide-by-1
    for (int s = 0; s < 4; s++) begin
      sel1 = 2'(s);
      settle(1, src_per[s]);
      expect_shape(src_per[s] / 2, src_per[s], $sformatf("R1 select %0d", s));
    end

    // R2/R3: every ratio code on synth C (period 4)
    sel1 = 2'd3;
    for (int c = 0; c < 16; c++) begin
      code1 = 4'(c);
      settle(div_tab[c], 4);
      expect_shape(exp_hi(div_tab[c], 4), div_tab[c] * 4,
                   $sformatf("R2 R3 code %0d", c));
    end

    // R6: two banks
    sel1 = 2'd1; code1 = 4'd2;   // synth A, /3
    sel2 = 2'd2; code2 = 4'd5;   // synth B, /6
    bank = 1'b0;
    settle(3, 6);
    expect_shape(exp_hi(3, 6), 18, "R6 bank 1");
    bank = 1'b1;
    settle(6, 10);
    expect_shape(exp_hi(6, 10), 60, "R6 bank 2");
    bank = 1'b0;

    // R9: enable alone, pin alone
    pd_en = 1'b1; pd_pin = 1'b0;
    settle(3, 6);
    expect_shape(exp_hi(3, 6), 18, "R9 enable only");
    pd_en = 1'b0; pd_pin = 1'b1;
    settle(3, 6);
    expect_shape(exp_hi(3, 6), 18, "R9 pin only");

    // R4: both set parks the output low
    pd_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(clk_o === 1'b0, "R4 powered down", int'(clk_o), 0);
      repeat (7) @(negedge clk);
    end

    // R5: release overrides power-down and running output
    oe = 1'b0;
    #1;
    check(clk_o === 1'bz, "R5 release with power-down", int'(clk_o === 1'bz), 1);
    pd_en = 1'b0; pd_pin = 1'b0;
    for (int k = 0; k < 5; k++) begin
      repeat (3) @(negedge clk);
      check(clk_o === 1'bz, "R5 release while running", int'(clk_o === 1'bz), 1);
    end
    oe = 1'b1;

    // R8: restart on ratio change, reference with /50
    sel1 = 2'd0; code1 = 4'd15;
    settle(50, 8);
    while (clk_o !== 1'b1) @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    repeat (20) @(negedge clk);
    code1 = 4'd3;
    repeat (3) @(negedge clk);
    check(clk_o === 1'b1, "R8 restart after code change", int'(clk_o), 1);
    settle(4, 8);
    expect_shape(exp_hi(4, 8), 32, "R8 new ratio");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule